// File: doc/BRIEF.md
# Lane-wise SIMD Floating-Point Minimum/Maximum Unit

This unit takes two 128-bit vector operands and produces, in each lane, the smaller or the larger of the two corresponding input lanes. Lanes are either 32-bit single-precision or 16-bit half-precision values. A width select chooses whether only the low 64 bits are processed or both 64-bit halves. The comparison orders signed zeros, flushes subnormals to zero and turns any NaN into a fixed default NaN. The unit therefore behaves as a vector min/max stage running under a standard, non-configurable floating-point control setting.

The unit also receives the decoded instruction bits it depends on: the format bit, the width bit, the operation bit and the least significant bit of each of the three register numbers. From these it flags illegal combinations as an undefined instruction. The result is registered one cycle after a valid request and is held until the next request. A flagged request returns an all-zero result.

Top module: `simd_fminmax`

## Requirements
- R1: `sel_half`=0 splits each operand into 32-bit lanes, with lane i at bits [32i+31:32i]. `sel_half`=1 splits it into 16-bit lanes, with lane i at bits [16i+15:16i]. Every lane is computed independently of the others.
- R2: `sel_min`=1 returns the smaller lane value and `sel_min`=0 returns the larger one.
- R3: The minimum of +0 and -0, in either operand order, is -0 (0x80000000 or 0x8000). The maximum of the same pair is +0.
- R4: If either input lane is a NaN (exponent all ones, non-zero fraction), whether quiet or signalling and whatever its sign, the output lane is the default NaN. The default NaN is 0x7FC00000 in a 32-bit lane and 0x7E00 in a 16-bit lane.
- R5: Non-NaN lanes are ordered by sign and then by magnitude. Any negative value is below any positive value, a larger magnitude is smaller among negatives, and -infinity and +infinity are the extreme values.
- R6: An input lane with a zero exponent (zero or subnormal) is replaced by a zero of the same sign before the comparison. A subnormal that wins therefore appears at the output as a signed zero.
- R7: `sel_wide`=0 processes bits [63:0] only and drives result bits [127:64] to zero. `sel_wide`=1 processes both halves in the same way.
- R8: With `sel_wide`=1, an odd register number in any of the destination, first source or second source (`rd_lsb`, `rn_lsb` or `rm_lsb` equal to 1) sets `undef_flag`, and the result is then all zero. With `sel_wide`=0, these bits have no effect.
- R9: When parameter HALF_EN is 0, a request with `sel_half`=1 sets `undef_flag`.
- R10: `result`, `undef_flag` and `out_valid`=1 appear on the first rising edge after `in_valid` is sampled high. While `in_valid` is low, `out_valid` is 0 and `result` and `undef_flag` hold their values.
- R11: While reset is asserted, `out_valid`, `undef_flag` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, loads the output registers |
| sel_min | input | 1 | Operation: 1 minimum, 0 maximum |
| sel_half | input | 1 | Lane format: 1 half precision, 0 single precision |
| sel_wide | input | 1 | 1 processes 128 bits, 0 processes the low 64 bits |
| rd_lsb | input | 1 | Least significant bit of the destination register number |
| rn_lsb | input | 1 | Least significant bit of the first source register number |
| rm_lsb | input | 1 | Least significant bit of the second source register number |
| op_a | input | 128 | First vector operand |
| op_b | input | 128 | Second vector operand |
| result | output | 128 | Registered lane-wise min/max result |
| out_valid | output | 1 | Result registered in the previous cycle |
| undef_flag | output | 1 | Registered undefined-instruction flag |

## Verification
The unit keeps no state beyond the output register. A wrong comparison or a wrong lane-format selection therefore shows up as a bad lane on `result` in the cycle right after the request. A wrong register enable shows as `result` changing during idle cycles or missing a request, and this can be seen one cycle later. The corner cases are the pairs where a bit-pattern comparison gives a different answer from the floating-point ordering: signed zeros, negative pairs, infinities, subnormals and NaNs of both kinds. Each of these is placed in its own lane, so a single request exposes a fault that affects only one lane.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  // lane formats: total width and exponent width
  localparam int unsigned SP_W   = 32;
  localparam int unsigned SP_EXP = 8;
  localparam int unsigned HP_W   = 16;
  localparam int unsigned HP_EXP = 5;

  typedef struct packed {
    logic want_min;
    logic half;
    logic wide;
  } fmm_mode_t;
endpackage

// File: rtl/fmm_lane.sv
module fmm_lane #(
  parameter int unsigned W     = 32,
  parameter int unsigned EXP_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         want_min_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned MAN_W = W - 1 - EXP_W;
  localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [EXP_W-1:0] a_exp, b_exp;
  logic [MAN_W-1:0] a_man, b_man;
  logic             any_nan;
  logic [W-1:0]     fa, fb;
  logic [W-2:0]     a_mag, b_mag;
  logic             a_below;

  always_comb begin
    a_exp   = a_i[W-2 -: EXP_W];
    b_exp   = b_i[W-2 -: EXP_W];
    a_man   = a_i[MAN_W-1:0];
    b_man   = b_i[MAN_W-1:0];
    any_nan = ((&a_exp) && (|a_man)) || ((&b_exp) && (|b_man));
    // zero-exponent inputs collapse to a signed zero
    fa = (a_exp == '0) ? {a_i[W-1], {(W-1){1'b0}}} : a_i;
    fb = (b_exp == '0) ? {b_i[W-1], {(W-1){1'b0}}} : b_i;
    a_mag = fa[W-2:0];
    b_mag = fb[W-2:0];
    if (fa[W-1] != fb[W-1]) begin
      a_below = fa[W-1];
    end else if (fa[W-1]) begin
      a_below = (b_mag < a_mag);
    end else begin
      a_below = (a_mag < b_mag);
    end
    if (any_nan) begin
      res_o = DNAN;
    end else if (want_min_i) begin
      res_o = a_below ? fa : fb;
    end else begin
      res_o = a_below ? fb : fa;
    end
  end
endmodule

// File: rtl/fmm_decode.sv
module fmm_decode #(
  parameter bit HALF_EN = 1'b1
) (
  input  logic half_i,
  input  logic wide_i,
  input  logic rd_lsb_i,
  input  logic rn_lsb_i,
  input  logic rm_lsb_i,
  output logic undef_o
);
  logic half_bad;
  logic odd_reg;

  generate
    if (HALF_EN) begin : g_half_ok
      assign half_bad = 1'b0;
    end else begin : g_half_off
      assign half_bad = half_i;
    end
  endgenerate

  assign odd_reg = wide_i && (rd_lsb_i || rn_lsb_i || rm_lsb_i);
  assign undef_o = odd_reg || half_bad;
endmodule

// File: rtl/fmm_datapath.sv
module fmm_datapath
  import fmm_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SEG_W = 64
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  fmm_mode_t        mode_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned N_SP = VEC_W / SP_W;
  localparam int unsigned N_HP = VEC_W / HP_W;

  logic [VEC_W-1:0] sp_res;
  logic [VEC_W-1:0] hp_res;

  generate
    for (genvar i = 0; i < N_SP; i++) begin : g_sp
      fmm_lane #(.W(SP_W), .EXP_W(SP_EXP)) u_lane (
        .a_i        (a_i[i*SP_W +: SP_W]),
        .b_i        (b_i[i*SP_W +: SP_W]),
        .want_min_i (mode_i.want_min),
        .res_o      (sp_res[i*SP_W +: SP_W])
      );
    end
    for (genvar j = 0; j < N_HP; j++) begin : g_hp
      fmm_lane #(.W(HP_W), .EXP_W(HP_EXP)) u_lane (
        .a_i        (a_i[j*HP_W +: HP_W]),
        .b_i        (b_i[j*HP_W +: HP_W]),
        .want_min_i (mode_i.want_min),
        .res_o      (hp_res[j*HP_W +: HP_W])
      );
    end
  endgenerate

  always_comb begin
    res_o = mode_i.half ? hp_res : sp_res;
    if (!mode_i.wide) begin
      res_o[VEC_W-1:SEG_W] = '0;
    end
  end
endmodule

// File: rtl/simd_fminmax.sv
module simd_fminmax
  import fmm_pkg::*;
#(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned SEG_W   = 64,
  parameter bit          HALF_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             sel_min,
  input  logic             sel_half,
  input  logic             sel_wide,
  input  logic             rd_lsb,
  input  logic             rn_lsb,
  input  logic             rm_lsb,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  output logic [VEC_W-1:0] result,
  output logic             out_valid,
  output logic             undef_flag
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  fmm_mode_t        mode;
  logic             undef_c;
  logic [VEC_W-1:0] dp_res;
  logic             load_en;
  logic [VEC_W-1:0] res_d, res_q;
  logic             und_d, und_q;
  logic             vld_d, vld_q;

  // assertion asynchronous, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign mode = '{want_min: sel_min, half: sel_half, wide: sel_wide};

  fmm_decode #(.HALF_EN(HALF_EN)) u_decode (
    .half_i   (sel_half),
    .wide_i   (sel_wide),
    .rd_lsb_i (rd_lsb),
    .rn_lsb_i (rn_lsb),
    .rm_lsb_i (rm_lsb),
    .undef_o  (undef_c)
  );

  fmm_datapath #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_datapath (
    .a_i    (op_a),
    .b_i    (op_b),
    .mode_i (mode),
    .res_o  (dp_res)
  );

  assign load_en = in_valid;

  always_comb begin
    vld_d = load_en;
    und_d = undef_c;
    res_d = undef_c ? '0 : dp_res;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      und_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        und_q <= und_d;
        res_q <= res_d;
      end
    end
  end

  assign result     = res_q;
  assign out_valid  = vld_q;
  assign undef_flag = und_q;
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SEG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             sel_min,
  input logic             sel_half,
  input logic             sel_wide,
  input logic             rd_lsb,
  input logic             rn_lsb,
  input logic             rm_lsb,
  input logic [VEC_W-1:0] op_a,
  input logic [VEC_W-1:0] op_b,
  input logic [VEC_W-1:0] result,
  input logic             out_valid,
  input logic             undef_flag
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(undef_flag)));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sel_wide) |=> (result[VEC_W-1:SEG_W] == '0));

  assert_odd_reg_undef_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_wide && (rd_lsb || rn_lsb || rm_lsb)) |=> (undef_flag && result == '0));

  assert_default_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sel_wide && !sel_half && (&op_a[30:23]) && (|op_a[22:0]))
      |=> (result[31:0] == 32'h7FC0_0000));

  assert_neg_zero_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sel_wide && !sel_half && sel_min && op_a[31:0] == 32'h0 &&
     op_b[31:0] == 32'h8000_0000) |=> (result[31:0] == 32'h8000_0000));
endmodule

bind simd_fminmax fmm_checker #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_fmm_checker (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .in_valid   (in_valid),
  .sel_min    (sel_min),
  .sel_half   (sel_half),
  .sel_wide   (sel_wide),
  .rd_lsb     (rd_lsb),
  .rn_lsb     (rn_lsb),
  .rm_lsb     (rm_lsb),
  .op_a       (op_a),
  .op_b       (op_b),
  .result     (result),
  .out_valid  (out_valid),
  .undef_flag (undef_flag)
);

// File: tb/simd_fminmax_tb.sv
module simd_fminmax_tb;
  typedef struct packed {
    logic         mn;
    logic         hf;
    logic         wd;
    logic [2:0]   lsb;   // {rd, rn, rm}
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
    logic         u;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [0:NV-1] = '{
    // 0: R1 R2 R5 max, fp32, wide
    '{1'b0, 1'b0, 1'b1, 3'b000,
      128'hC0000000_3F800000_7F800000_BF800000, 128'hBF800000_40000000_3F800000_FF800000,
      128'hBF800000_40000000_7F800000_BF800000, 1'b0},
    // 1: R2 R5 min, same operands
    '{1'b1, 1'b0, 1'b1, 3'b000,
      128'hC0000000_3F800000_7F800000_BF800000, 128'hBF800000_40000000_3F800000_FF800000,
      128'hC0000000_3F800000_3F800000_FF800000, 1'b0},
    // 2: R3 min of signed zeros
    '{1'b1, 1'b0, 1'b1, 3'b000,
      128'h00000000_80000000_00000000_80000000, 128'h80000000_00000000_00000000_80000000,
      128'h80000000_80000000_00000000_80000000, 1'b0},
    // 3: R3 max of signed zeros
    '{1'b0, 1'b0, 1'b1, 3'b000,
      128'h00000000_80000000_00000000_80000000, 128'h80000000_00000000_00000000_80000000,
      128'h00000000_00000000_00000000_80000000, 1'b0},
    // 4: R4 signalling, quiet and negative NaNs in fp32 lanes
    '{1'b1, 1'b0, 1'b1, 3'b000,
      128'h7F800001_3F800000_FFC00000_3F800000, 128'h3F800000_7FC00001_3F800000_40000000,
      128'h7FC00000_7FC00000_7FC00000_3F800000, 1'b0},
    // 5: R6 subnormals flushed to signed zero
    '{1'b1, 1'b0, 1'b1, 3'b000,
      128'h00000001_80000005_00000001_3F800000, 128'h3F800000_00000000_80000000_00000003,
      128'h00000000_80000000_80000000_00000000, 1'b0},
    // 6: R7 narrow form clears upper half; R8 odd bits ignored when narrow
    '{1'b0, 1'b0, 1'b0, 3'b111,
      128'h3F800000_3F800000_40000000_C0000000, 128'h40000000_40000000_3F800000_BF800000,
      128'h00000000_00000000_40000000_BF800000, 1'b0},
    // 7: R1 R3 R5 fp16 min
    '{1'b1, 1'b1, 1'b1, 3'b000,
      128'h3C00_4000_BC00_C000_7C00_FC00_0000_8000, 128'h4000_3C00_C000_BC00_3C00_3C00_8000_0000,
      128'h3C00_3C00_C000_C000_3C00_FC00_8000_8000, 1'b0},
    // 8: R1 R3 fp16 max
    '{1'b0, 1'b1, 1'b1, 3'b000,
      128'h3C00_4000_BC00_C000_7C00_FC00_0000_8000, 128'h4000_3C00_C000_BC00_3C00_3C00_8000_0000,
      128'h4000_4000_BC00_BC00_7C00_3C00_0000_0000, 1'b0},
    // 9: R4 R6 R7 fp16 NaN and subnormal, narrow
    '{1'b1, 1'b1, 1'b0, 3'b000,
      128'h1111_2222_3333_4444_7C01_0001_3C00_7E00, 128'h5555_6666_7777_8888_3C00_8000_8003_3C00,
      128'h0000_0000_0000_0000_7E00_8000_8000_7E00, 1'b0},
    // 10: R8 odd destination, wide
    '{1'b1, 1'b0, 1'b1, 3'b100,
      128'h3F800000_3F800000_3F800000_3F800000, 128'h40000000_40000000_40000000_40000000,
      128'h0, 1'b1},
    // 11: R8 odd first source
    '{1'b0, 1'b0, 1'b1, 3'b010,
      128'h3F800000_3F800000_3F800000_3F800000, 128'h40000000_40000000_40000000_40000000,
      128'h0, 1'b1},
    // 12: R8 odd second source
    '{1'b0, 1'b1, 1'b1, 3'b001,
      128'h3F800000_3F800000_3F800000_3F800000, 128'h40000000_40000000_40000000_40000000,
      128'h0, 1'b1},
    // 13: R2 max with even registers, wide, after flagged requests
    '{1'b0, 1'b0, 1'b1, 3'b000,
      128'h3F800000_BF800000_7F800000_00000000, 128'h40000000_C0000000_FF800000_80000000,
      128'h40000000_BF800000_7F800000_00000000, 1'b0}
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         sel_min, sel_half, sel_wide;
  logic         rd_lsb, rn_lsb, rm_lsb;
  logic [127:0] op_a, op_b;
  logic [127:0] result, result_nh;
  logic         out_valid, out_valid_nh;
  logic         undef_flag, undef_nh;

  int checks;
  int errors;
  bit done;

  simd_fminmax u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_min(sel_min),
    .sel_half(sel_half), .sel_wide(sel_wide), .rd_lsb(rd_lsb), .rn_lsb(rn_lsb),
    .rm_lsb(rm_lsb), .op_a(op_a), .op_b(op_b), .result(result),
    .out_valid(out_valid), .undef_flag(undef_flag)
  );

  simd_fminmax #(.HALF_EN(1'b0)) u_dut_nh (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_min(sel_min),
    .sel_half(sel_half), .sel_wide(sel_wide), .rd_lsb(rd_lsb), .rn_lsb(rn_lsb),
    .rm_lsb(rm_lsb), .op_a(op_a), .op_b(op_b), .result(result_nh),
    .out_valid(out_valid_nh), .undef_flag(undef_nh)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic mn, input logic hf, input logic wd, input logic [2:0] lsb,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    sel_min  = mn;
    sel_half = hf;
    sel_wide = wd;
    {rd_lsb, rn_lsb, rm_lsb} = lsb;
    op_a = a;
    op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [127:0] held;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; sel_min = 1'b0; sel_half = 1'b0; sel_wide = 1'b0;
    rd_lsb = 1'b0; rn_lsb = 1'b0; rm_lsb = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {127'b0, out_valid}, 128'h0);
    chk("R11 result", result, 128'h0);
    chk("R11 undef_flag", {127'b0, undef_flag}, 128'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].mn, VECS[i].hf, VECS[i].wd, VECS[i].lsb, VECS[i].a, VECS[i].b);
      chk($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 vector %0d result", i), result, VECS[i].e);
      chk($sformatf("R8 vector %0d undef", i), {127'b0, undef_flag}, {127'b0, VECS[i].u});
      chk($sformatf("R10 vector %0d out_valid", i), {127'b0, out_valid}, 128'h1);
    end

    // R10 hold while idle
    drive(1'b1, 1'b0, 1'b1, 3'b000, 128'h3F800000_3F800000_3F800000_3F800000,
          128'hBF800000_BF800000_BF800000_BF800000);
    held = result;
    chk("R10 loaded", held, 128'hBF800000_BF800000_BF800000_BF800000);
    op_a = '0; op_b = '0; sel_min = 1'b0; sel_wide = 1'b1; rd_lsb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 result held", result, held);
    chk("R10 out_valid low", {127'b0, out_valid}, 128'h0);
    chk("R10 undef held", {127'b0, undef_flag}, 128'h0);
    rd_lsb = 1'b0;

    // R9 half precision disabled
    drive(1'b1, 1'b1, 1'b1, 3'b000, 128'h3C00_3C00_3C00_3C00_3C00_3C00_3C00_3C00,
          128'h4000_4000_4000_4000_4000_4000_4000_4000);
    chk("R9 half off undef", {127'b0, undef_nh}, 128'h1);
    chk("R9 half off result", result_nh, 128'h0);
    chk("R9 half on no undef", {127'b0, undef_flag}, 128'h0);
    chk("R9 half on result", result, 128'h3C00_3C00_3C00_3C00_3C00_3C00_3C00_3C00);
    drive(1'b0, 1'b0, 1'b1, 3'b000, 128'h3F800000_3F800000_3F800000_3F800000,
          128'h40000000_40000000_40000000_40000000);
    chk("R9 half off single ok", {127'b0, undef_nh}, 128'h0);
    chk("R9 half off single result", result_nh, 128'h40000000_40000000_40000000_40000000);

    // R11 reset during operation clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 mid reset result", result, 128'h0);
    chk("R11 mid reset out_valid", {127'b0, out_valid}, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 after release", result, 128'h0);

    finish_run();
  end
endmodule